// File: doc/BRIEF.md
# Dead-Line Victim Selector for an Instruction Cache

This block picks the way to replace when an instruction fetch misses in a set-associative instruction cache. It guesses, for each line in a set, whether the line will be fetched again before it would leave the cache. The guess comes from a table of small saturating counters. The table is indexed by a signature that mixes the fetch line address with a shift register of recent conditional-branch outcomes. Each resident line keeps the signature it was last touched under, so that the same table entry can be trained when the line is hit again or evicted.

The block watches one fetch access per cycle: a set index, a hit flag, the way that hit, and the fetch PC. A separate port feeds branch outcomes into the history register. On a miss, the victim way appears combinationally in the same cycle. At the next clock edge the block records the fill, trains the table and updates the recency bits. The data array, the tags and the refill path belong to the surrounding cache.

Each table entry is a 2-bit counter, and a value of 2 or more means "dead". Hits lower the counter held under the line's stored signature. Evictions push the evicted line's counter back toward the threshold: a line that was thrown out while predicted dead loses confidence, and a line that had to go by recency gains it. Because of this, a wrong dead guess cannot keep confirming itself.

Top module: `dead_line_repl`

## Requirements
- R1: The history register starts at zero. On each cycle with `br_valid` high it shifts left by one bit and takes `br_taken` (1 = taken) into bit 0. An access in the same cycle uses the value held before that shift.
- R2: The access signature is computed in two steps. First, the line address (`acc_pc` with its low OFF_W bits dropped) is XORed with the zero-extended history. Second, that value is cut into IDX_W-bit chunks starting from bit 0, and all the chunks are XORed together.
- R3: On a miss (`acc_valid`=1, `acc_hit`=0), if any way of the set is invalid, `victim_way` is the lowest-numbered invalid way and `victim_dead` is 0.
- R4: On a miss into a full set, a way is predicted dead when its counter, read at the way's stored signature, is 2 or 3. If any way is predicted dead, the victim is the lowest-numbered dead way whose recency bit is 0. If every dead way has its recency bit at 1, the victim is the lowest-numbered dead way. In both cases `victim_dead` is 1.
- R5: On a miss into a full set with no way predicted dead, the victim is the lowest-numbered way whose recency bit is 0, and `victim_dead` is 0.
- R6: Every access (a hit, or a fill of the victim) sets the recency bit of the touched way. If that would make every bit of the set 1, only the touched way's bit is left set.
- R7: A hit decrements, saturating at 0, the counter at the hit way's stored signature. The way then stores the current signature.
- R8: A fill that replaces a valid line adjusts the counter at that line's stored signature. A value of 2 or 3 is decremented. A value of 0 or 1 is incremented, saturating at 3. The filled way becomes valid and stores the current signature.
- R9: After reset every way is invalid, every counter and recency bit is 0, and the history is 0.
- R10: Cycles with `acc_valid` low change no line state and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A fetch access is presented this cycle |
| acc_hit | input | 1 | The access hit in the cache |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way that hit (used when `acc_hit` is 1) |
| acc_pc | input | PC_W | Fetch PC of the access |
| br_valid | input | 1 | A conditional branch resolved this cycle |
| br_taken | input | 1 | Outcome of that branch, 1 = taken |
| victim_way | output | WAY_W | Way to fill on a miss |
| victim_dead | output | 1 | The victim was chosen by a dead prediction |

## Verification
Two things can happen in the same cycle: a branch outcome shifting the history, and a fetch access computing and storing a signature. The access must use the history held before the shift. The bench runs a long stream in which branches and accesses coincide freely on a small configuration. It keeps its own model of history, stored signatures and counters, and judges the result through later victim choices. A signature built from the post-shift history would read a different counter and change which way is predicted dead.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX = 2'd3;
  localparam ctr_t DEAD_AT = 2'd2;

  function automatic ctr_t ctr_up(ctr_t c);
    return (c == CTR_MAX) ? c : c + 2'd1;
  endfunction

  function automatic ctr_t ctr_down(ctr_t c);
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_dead(ctr_t c);
    return c >= DEAD_AT;
  endfunction
endpackage

// File: rtl/dlr_history.sv
module dlr_history #(
  parameter int HIST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_taken,
  output logic [HIST_W-1:0] hist_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else if (br_valid) hist_q <= {hist_q[HIST_W-2:0], br_taken};
  end
endmodule

// File: rtl/dlr_line_state.sv
module dlr_line_state #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int IDX_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0]             set_valid,
  output logic [WAYS-1:0]             set_mru,
  output logic [WAYS-1:0][IDX_W-1:0]  set_sigs,
  input  logic                        upd_en,
  input  logic                        upd_fill,
  input  logic [WAY_W-1:0]            upd_way,
  input  logic [IDX_W-1:0]            upd_sig
);
  logic [WAYS-1:0]  val_q [SETS];
  logic [WAYS-1:0]  mru_q [SETS];
  logic [IDX_W-1:0] sig_q [SETS][WAYS];

  function automatic logic [WAYS-1:0] touch(logic [WAYS-1:0] cur, logic [WAY_W-1:0] w);
    logic [WAYS-1:0] one;
    logic [WAYS-1:0] nxt;
    one = '0;
    one[w] = 1'b1;
    nxt = cur | one;
    return (&nxt) ? one : nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        mru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) sig_q[s][w] <= '0;
      end
    end else if (upd_en) begin
      mru_q[rd_set] <= touch(mru_q[rd_set], upd_way);
      sig_q[rd_set][upd_way] <= upd_sig;
      if (upd_fill) val_q[rd_set][upd_way] <= 1'b1;
    end
  end

  always_comb begin
    set_valid = val_q[rd_set];
    set_mru   = mru_q[rd_set];
    for (int w = 0; w < WAYS; w++) set_sigs[w] = sig_q[rd_set][w];
  end
endmodule

// File: rtl/dlr_ctr_table.sv
module dlr_ctr_table
  import dlr_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0][IDX_W-1:0] rd_idx,
  output logic [WAYS-1:0]            rd_dead,
  input  logic                       trn_en,
  input  logic [IDX_W-1:0]           trn_idx,
  input  logic                       trn_up
);
  ctr_t cnt [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= '0;
    end else if (trn_en) begin
      cnt[trn_idx] <= trn_up ? ctr_up(cnt[trn_idx]) : ctr_down(cnt[trn_idx]);
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign rd_dead[w] = ctr_dead(cnt[rd_idx[w]]);
    end
  endgenerate
endmodule

// File: rtl/dlr_victim_pick.sv
module dlr_victim_pick #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  dead,
  input  logic [WAYS-1:0]  mru,
  output logic [WAY_W-1:0] pick_way,
  output logic             pick_dead
);
  function automatic logic [WAY_W-1:0] lowest(logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  logic [WAYS-1:0] free_v;
  logic [WAYS-1:0] dead_old;

  assign free_v   = ~valid;
  assign dead_old = dead & ~mru;

  always_comb begin
    if (|free_v) begin
      pick_way  = lowest(free_v);
      pick_dead = 1'b0;
    end else if (|dead_old) begin
      pick_way  = lowest(dead_old);
      pick_dead = 1'b1;
    end else if (|dead) begin
      pick_way  = lowest(dead);
      pick_dead = 1'b1;
    end else begin
      pick_way  = lowest(~mru);
      pick_dead = 1'b0;
    end
  end
endmodule

// File: rtl/dead_line_repl.sv
module dead_line_repl #(
  parameter int PC_W   = 32,
  parameter int OFF_W  = 6,
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int HIST_W = 16,
  parameter int IDX_W  = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [PC_W-1:0]  acc_pc,
  input  logic             br_valid,
  input  logic             br_taken,
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_dead
);
  localparam int LINE_W = PC_W - OFF_W;
  localparam int X_W    = (LINE_W > HIST_W) ? LINE_W : HIST_W;
  localparam int NCHUNK = (X_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  function automatic logic [IDX_W-1:0] fold_sig(logic [LINE_W-1:0] la, logic [HIST_W-1:0] h);
    logic [PAD_W-1:0] x;
    logic [IDX_W-1:0] r;
    x = '0;
    x[LINE_W-1:0] = la;
    x[HIST_W-1:0] = x[HIST_W-1:0] ^ h;
    r = '0;
    for (int c = 0; c < NCHUNK; c++) r = r ^ x[c*IDX_W +: IDX_W];
    return r;
  endfunction

  logic [HIST_W-1:0]            hist_q;
  logic [IDX_W-1:0]             cur_sig;
  logic [WAYS-1:0]              set_valid;
  logic [WAYS-1:0]              set_mru;
  logic [WAYS-1:0][IDX_W-1:0]   set_sigs;
  logic [WAYS-1:0]              set_dead;
  logic [WAY_W-1:0]             pick_way;
  logic                         pick_dead;
  logic                         hit_fire;
  logic                         miss_fire;
  logic                         evict_fire;
  logic [WAY_W-1:0]             upd_way;
  logic                         trn_en;
  logic [IDX_W-1:0]             trn_idx;
  logic                         trn_up;

  dlr_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken), .hist_q(hist_q)
  );

  assign cur_sig = fold_sig(acc_pc[PC_W-1:OFF_W], hist_q);

  dlr_line_state #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .rd_set(acc_set),
    .set_valid(set_valid), .set_mru(set_mru), .set_sigs(set_sigs),
    .upd_en(acc_valid), .upd_fill(miss_fire), .upd_way(upd_way), .upd_sig(cur_sig)
  );

  dlr_ctr_table #(.WAYS(WAYS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_idx(set_sigs), .rd_dead(set_dead),
    .trn_en(trn_en), .trn_idx(trn_idx), .trn_up(trn_up)
  );

  dlr_victim_pick #(.WAYS(WAYS)) u_pick (
    .valid(set_valid), .dead(set_dead), .mru(set_mru),
    .pick_way(pick_way), .pick_dead(pick_dead)
  );

  assign hit_fire   = acc_valid && acc_hit;
  assign miss_fire  = acc_valid && !acc_hit;
  assign evict_fire = miss_fire && set_valid[pick_way];
  assign upd_way    = acc_hit ? acc_way : pick_way;

  always_comb begin
    trn_en  = hit_fire || evict_fire;
    trn_idx = set_sigs[upd_way];
    trn_up  = evict_fire && !set_dead[pick_way];
  end

  assign victim_way  = pick_way;
  assign victim_dead = pick_dead;
endmodule

// File: rtl/dlr_checker.sv
module dlr_checker #(
  parameter int WAYS   = 8,
  parameter int HIST_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_hit,
  input logic              br_valid,
  input logic              br_taken,
  input logic [HIST_W-1:0] hist_q,
  input logic [WAYS-1:0]   set_valid,
  input logic [WAYS-1:0]   set_dead,
  input logic [WAYS-1:0]   set_mru,
  input logic [WAY_W-1:0]  victim_way,
  input logic              victim_dead
);
  p_hist_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (hist_q[0] == $past(br_taken)) && (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

  p_hist_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(hist_q));

  p_free_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && !(&set_valid)) |-> (!set_valid[victim_way] && !victim_dead));

  p_dead_pref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && (&set_valid) && (|set_dead)) |-> (set_dead[victim_way] && victim_dead));

  p_lru_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && (&set_valid) && !(|set_dead)) |-> (!set_mru[victim_way] && !victim_dead));

  p_mru_not_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&set_mru));
endmodule

bind dead_line_repl dlr_checker #(.WAYS(WAYS), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
  .br_valid(br_valid), .br_taken(br_taken), .hist_q(hist_q),
  .set_valid(set_valid), .set_dead(set_dead), .set_mru(set_mru),
  .victim_way(victim_way), .victim_dead(victim_dead)
);

// File: tb/dead_line_repl_test.sv
module dead_line_repl_test;
  localparam int PW = 16, OFF = 6, NS = 4, NW = 4, HW = 8, IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_hit = 1'b0, br_valid = 1'b0, br_taken = 1'b0;
  logic [1:0] acc_set = '0, acc_way = '0;
  logic [PW-1:0] acc_pc = '0;
  logic [1:0] victim_way;
  logic victim_dead;

  int checks = 0, errors = 0, dead_hits = 0;
  int m_cnt [16];
  int m_sig [NS][NW];
  bit m_val [NS][NW];
  bit m_mru [NS][NW];
  int m_tag [NS][NW];
  int m_hist = 0;
  int obs_way = 0;
  bit obs_dead = 0;
  bit prev_idle = 0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  dead_line_repl #(.PC_W(PW), .OFF_W(OFF), .SETS(NS), .WAYS(NW), .HIST_W(HW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_set(acc_set),
    .acc_way(acc_way), .acc_pc(acc_pc), .br_valid(br_valid), .br_taken(br_taken),
    .victim_way(victim_way), .victim_dead(victim_dead)
  );

  function automatic int sig_of(int pc, int h);
    int x = ((pc >> OFF) & 32'h3FF) ^ h;
    int r = 0;
    while (x != 0) begin
      r = r ^ (x & 15);
      x = x >> 4;
    end
    return r;
  endfunction

  task automatic predict(input int s, output int v, output bit d, output string rule);
    v = -1; d = 0; rule = "R5";
    for (int w = NW - 1; w >= 0; w--) if (!m_val[s][w]) v = w;
    if (v >= 0) begin rule = "R3"; return; end
    for (int w = NW - 1; w >= 0; w--) if (m_cnt[m_sig[s][w]] >= 2 && !m_mru[s][w]) v = w;
    if (v < 0) for (int w = NW - 1; w >= 0; w--) if (m_cnt[m_sig[s][w]] >= 2) v = w;
    if (v >= 0) begin d = 1; rule = "R4"; return; end
    for (int w = NW - 1; w >= 0; w--) if (!m_mru[s][w]) v = w;
  endtask

  task automatic touch(input int s, input int w);
    bit full = 1;
    m_mru[s][w] = 1;
    for (int i = 0; i < NW; i++) full = full & m_mru[s][i];
    if (full) for (int i = 0; i < NW; i++) m_mru[s][i] = (i == w);
  endtask

  task automatic step(input bit bv, input bit bt, input bit av, input int line, input int low);
    int s = line & 3;
    int hw = -1;
    int pc = (line << OFF) | low;
    int v;
    bit d;
    string rule;
    @(negedge clk);
    for (int w = 0; w < NW; w++) if (m_val[s][w] && m_tag[s][w] == line) hw = w;
    br_valid = bv; br_taken = bt; acc_valid = av;
    acc_set = 2'(s); acc_pc = PW'(pc);
    acc_hit = (hw >= 0); acc_way = 2'((hw >= 0) ? hw : 0);
    #8;
    if (av && hw < 0) begin
      predict(s, v, d, rule);
      obs_way = int'(victim_way); obs_dead = victim_dead;
      checks++;
      if (d) dead_hits++;
      if (obs_way != v || obs_dead != d) begin
        errors++;
        $display("FAIL %s%s (training per R1 R2 R6 R7 R8): set %0d way=%0d dead=%0d expected way=%0d dead=%0d",
                 rule, prev_idle ? " after idle R10" : "", s, obs_way, obs_dead, v, d);
      end
    end
    @(posedge clk); #1;
    if (av) begin
      int sg = sig_of(pc, m_hist);
      if (hw >= 0) begin
        if (m_cnt[m_sig[s][hw]] > 0) m_cnt[m_sig[s][hw]]--;
        m_sig[s][hw] = sg; touch(s, hw);
      end else begin
        if (m_val[s][v]) begin
          if (m_cnt[m_sig[s][v]] >= 2) m_cnt[m_sig[s][v]]--;
          else m_cnt[m_sig[s][v]]++;
        end
        m_val[s][v] = 1; m_tag[s][v] = line; m_sig[s][v] = sg; touch(s, v);
      end
    end
    if (bv) m_hist = ((m_hist << 1) | int'(bt)) & 8'hFF;
    prev_idle = !av;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin
      m_sig[s][w] = 0; m_val[s][w] = 0; m_mru[s][w] = 0; m_tag[s][w] = -1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9: after reset each set is empty, so the first miss takes way 0, not dead
    for (int s = 0; s < NS; s++) begin
      step(1'b0, 1'b0, 1'b1, s, 0);
      checks++;
      if (obs_way != 0 || obs_dead != 0) begin
        errors++;
        $display("FAIL R9: set %0d way=%0d dead=%0d expected way=0 dead=0", s, obs_way, obs_dead);
      end
    end
    // R10: idle cycles with wandering inputs must leave state untouched
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, i * 5, i);
    step(1'b0, 1'b0, 1'b1, 4, 0);
    // Main sweep: branch shifts and accesses share cycles freely (R1 ordering)
    for (int n = 0; n < 6000; n++) begin
      lf = lf[0] ? ((lf >> 1) ^ 16'hB400) : (lf >> 1);
      step(lf[0], lf[1], lf[3:2] != 2'b00, int'(lf[9:4]) % 24, int'(lf[15:10]));
    end
    checks++;
    if (dead_hits == 0) begin
      errors++;
      $display("FAIL R4: dead-predicted victims seen=%0d expected >0", dead_hits);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule